// File: doc/BRIEF.md
# Parallel Bus Memory Slave

This block is a byte-wide memory extension for a host controller that reaches it over an asynchronous parallel bus. The host places a 16-bit address on the bus and pulls one of two active-low strobes low: the write strobe to store a byte, the read strobe to fetch one. The slave brings both strobes into its own clock domain through synchronisers. A transfer starts only on a falling edge of one strobe while the other is high.

When the transfer is done, the slave drives a shared acknowledge line high. The slave only ever drives this line high. Once it sees the line high it stops driving it, and the host pulls the line low to close the transfer. On a read, the slave drives the data bus from the moment the byte is ready until the read strobe goes back high.

The storage holds 512 bytes in four banks of 128 bytes each, decoded from the address window 0x1800 to 0x19FF. Writes to addresses outside this window are acknowledged and dropped. Reads outside the window return zero.

Top module: `pbus_mem_slave`

## Requirements
- R1: A write transfer (write strobe falls while the read strobe is high) stores the data byte at the addressed location, and a later read of that address returns it.
- R2: A read transfer (read strobe falls while the write strobe is high) presents the stored byte on `data_o` with `data_oe_o` high by the time acknowledge is seen high.
- R3: After a strobe falls, the slave drives the acknowledge line (`ack_oe_o` high, `ack_o` = 1) within 6 clock cycles.
- R4: The slave stops driving acknowledge (`ack_oe_o` falls) only after it has observed the line high, and it never drives the line low.
- R5: Storage is mapped to addresses 0x1800 to 0x19FF, split into four 128-byte banks selected by address bits [8:7]. A write outside the window is acknowledged but leaves every stored byte unchanged, including the byte whose low address bits it shares.
- R6: A read outside the window is acknowledged and returns 0x00.
- R7: `data_oe_o` stays high after a read until the read strobe has returned high, then falls within 4 cycles. It is never high during a write transfer.
- R8: No new transfer is accepted until both strobes are high and the acknowledge line has been observed low. A strobe that falls while the line is still high gets no acknowledge and has no effect.
- R9: If both strobes fall together, no transfer starts and no acknowledge is given.
- R10: During and just after reset, `ack_oe_o` and `data_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 16 | Bus address from the host |
| data_i | input | 8 | Data bus as sampled by the slave |
| data_o | output | 8 | Byte driven onto the data bus on reads |
| data_oe_o | output | 1 | Data bus driver enable |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| ack_i | input | 1 | Sampled level of the shared acknowledge line |
| ack_o | output | 1 | Value driven on acknowledge (always high) |
| ack_oe_o | output | 1 | Acknowledge driver enable |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, a base address of 0x1800 and four banks of 128 bytes. This exposes all four banks and both edges of the window: 0x17FF, 0x1800, 0x19FF, and 0x1A00, whose low bits alias 0x1800 when truncated. Random transfers mix in-window and out-of-window addresses. Directed cases cover strobes that fall while acknowledge is still high and strobes that fall together.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_ACK   = 3'd3,
    ST_CLOSE = 3'd4
  } pbm_state_e;
endpackage

// File: rtl/pbm_sync.sv
module pbm_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/pbm_decode.sv
module pbm_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BASE       = 32'h1800,
  parameter int unsigned BANK_BYTES = 128,
  parameter int unsigned NUM_BANKS  = 4,
  localparam int unsigned DEPTH     = BANK_BYTES * NUM_BANKS,
  localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W:0]   DEPTH_W = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr_i - BASE_A;
    hit_o  = (addr_i >= BASE_A) && ({1'b0, offset} < DEPTH_W);
    idx_o  = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/pbm_store.sv
module pbm_store #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_BYTES = 128,
  parameter int unsigned NUM_BANKS  = 4,
  localparam int unsigned BANK_AW   = $clog2(BANK_BYTES),
  localparam int unsigned SEL_W     = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W     = BANK_AW + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BANK_AW-1:0] off;
  logic [SEL_W-1:0]   sel;
  logic [DATA_W-1:0]  bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we;
  logic [DATA_W-1:0]  rdata_d, rdata_q;

  assign off = idx_i[BANK_AW-1:0];
  assign sel = idx_i[IDX_W-1:BANK_AW];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_BYTES];
    assign bank_we[g] = we_i && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (bank_we[g]) begin
        mem[off] <= wdata_i;
      end
    end
    assign bank_rd[g] = mem[off];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re_i) begin
      rdata_d = hit_i ? bank_rd[sel] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R5
  bank_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
endmodule

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_s_i,
  input  logic rd_s_i,
  input  logic ack_s_i,
  input  logic hit_i,
  output logic cap_o,
  output logic we_o,
  output logic re_o,
  output logic data_oe_o,
  output logic ack_oe_o
);
  pbm_state_e state_q, state_d;
  logic wr_d_q, rd_d_q;
  logic oe_q, oe_d;
  logic wr_fall, rd_fall;

  assign wr_fall = wr_d_q && !wr_s_i;
  assign rd_fall = rd_d_q && !rd_s_i;

  always_comb begin
    state_d  = state_q;
    oe_d     = oe_q;
    cap_o    = 1'b0;
    we_o     = 1'b0;
    re_o     = 1'b0;
    ack_oe_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_fall && rd_s_i) begin
          cap_o   = 1'b1;
          state_d = ST_WR;
        end else if (rd_fall && wr_s_i) begin
          cap_o   = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_WR: begin
        we_o    = hit_i;
        state_d = ST_ACK;
      end
      ST_RD: begin
        re_o    = 1'b1;
        oe_d    = 1'b1;
        state_d = ST_ACK;
      end
      ST_ACK: begin
        ack_oe_o = 1'b1;
        if (ack_s_i) state_d = ST_CLOSE;
      end
      ST_CLOSE: begin
        if (rd_s_i) oe_d = 1'b0;
        if (rd_s_i && wr_s_i && !ack_s_i) state_d = ST_IDLE;
      end
      default: begin
        oe_d    = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      wr_d_q  <= 1'b1;
      rd_d_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      wr_d_q  <= wr_s_i;
      rd_d_q  <= rd_s_i;
    end
  end

  assign data_oe_o = oe_q;

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe_o) |-> $past(ack_s_i));

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(rd_s_i));

  // R7
  oe_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR) |-> !oe_q);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) == ST_CLOSE)
      |-> ($past(wr_s_i) && $past(rd_s_i) && !$past(ack_s_i)));

  // R9
  no_double_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wr_s_i && !rd_s_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pbus_mem_slave.sv
module pbus_mem_slave #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BASE       = 32'h1800,
  parameter int unsigned BANK_BYTES = 128,
  parameter int unsigned NUM_BANKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic              ack_i,
  output logic              ack_o,
  output logic              ack_oe_o
);
  localparam int unsigned DEPTH = BANK_BYTES * NUM_BANKS;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic rst_meta_q, rst_sync_q;
  logic [1:0] strb_s;
  logic ack_s;
  logic cap, we, re, hit;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pbm_sync #(.W(2), .RST_VAL(1'b1)) u_strb_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d_i  ({wr_n_i, rd_n_i}),
    .q_o  (strb_s)
  );

  pbm_sync #(.W(1), .RST_VAL(1'b0)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d_i  (ack_i),
    .q_o  (ack_s)
  );

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (cap) begin
      addr_d  = addr_i;
      wdata_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  pbm_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS)
  ) u_decode (
    .addr_i(addr_q),
    .hit_o (hit),
    .idx_o (idx)
  );

  pbm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_s_i   (strb_s[1]),
    .rd_s_i   (strb_s[0]),
    .ack_s_i  (ack_s),
    .hit_i    (hit),
    .cap_o    (cap),
    .we_o     (we),
    .re_o     (re),
    .data_oe_o(data_oe_o),
    .ack_oe_o (ack_oe_o)
  );

  pbm_store #(
    .DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .we_i   (we),
    .re_i   (re),
    .hit_i  (hit),
    .idx_i  (idx),
    .wdata_i(wdata_q),
    .rdata_o(data_o)
  );

  assign ack_o = 1'b1;

  // R5
  write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    we |-> hit);

  // R6
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (re && !hit) |=> (data_o == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (!ack_oe_o && !data_oe_o));
endmodule

// File: tb/pbus_mem_slave_tb_top.sv
module pbus_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] addr;
  logic [7:0]  wdat;
  logic wr_n, rd_n, host_clr, ack_keep;
  logic [7:0] data_o;
  logic data_oe, ack_o, ack_oe;
  wire  ack_line = ack_oe ? ack_o : ack_keep;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [512];
  bit         known [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(wdat),
    .data_o(data_o), .data_oe_o(data_oe), .wr_n_i(wr_n), .rd_n_i(rd_n),
    .ack_i(ack_line), .ack_o(ack_o), .ack_oe_o(ack_oe)
  );

  always @(posedge clk) begin
    if (!rst_n)        ack_keep <= 1'b0;
    else if (ack_oe)   ack_keep <= ack_o;
    else if (host_clr) ack_keep <= 1'b0;
  end

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h1800) && (a <= 16'h19FF);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    logic [15:0] o;
    o = a - 16'h1800;
    return in_win(a) ? model[o[8:0]] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(output int cyc);
    cyc = 0;
    while (!ack_line && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic wait_release();
    int n = 0;
    while (ack_oe && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(!ack_oe, "R4 release", int'(ack_oe), 0);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    int cyc;
    logic [15:0] o;
    @(negedge clk);
    addr = a; wdat = d; wr_n = 1'b0;
    wait_ack(cyc);
    chk(cyc >= 1 && cyc <= 6, "R3 write ack latency", cyc, 4);
    chk(!data_oe, "R7 no drive on write", int'(data_oe), 0);
    wait_release();
    chk(ack_line, "R4 line left high", int'(ack_line), 1);
    wr_n = 1'b1; host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    repeat (4) @(negedge clk);
    if (in_win(a)) begin
      o = a - 16'h1800;
      model[o[8:0]] = d;
      known[o[8:0]] = 1'b1;
    end
  endtask

  task automatic bus_read(input logic [15:0] a, input string req);
    int cyc;
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    addr = a; rd_n = 1'b0;
    wait_ack(cyc);
    chk(cyc >= 1 && cyc <= 6, "R3 read ack latency", cyc, 4);
    chk(data_oe, "R2 driver on at ack", int'(data_oe), 1);
    chk(data_o == e, req, int'(data_o), int'(e));
    wait_release();
    chk(data_oe, "R7 driver held while strobe low", int'(data_oe), 1);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!data_oe, "R7 driver off after strobe high", int'(data_oe), 0);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ack_oe || data_oe) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) begin
      known[i] = 1'b0;
      model[i] = 8'h00;
    end
    rst_n = 1'b0; addr = '0; wdat = '0; wr_n = 1'b1; rd_n = 1'b1; host_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ack_oe && !data_oe, "R10 reset outputs", int'({ack_oe, data_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_oe && !data_oe, "R10 after release", int'({ack_oe, data_oe}), 0);
    repeat (4) @(negedge clk);

    // R1 / R5: bank edges
    bus_write(16'h1800, 8'hA5);
    bus_write(16'h187F, 8'h3C);
    bus_write(16'h1880, 8'h5A);
    bus_write(16'h19FF, 8'hC3);
    bus_read(16'h1800, "R1 bank0 low");
    bus_read(16'h187F, "R1 bank0 high");
    bus_read(16'h1880, "R1 bank1 low");
    bus_read(16'h19FF, "R1 bank3 high");

    // R5: out-of-window writes that alias low bits
    bus_write(16'h1A00, 8'h11);
    bus_write(16'h17FF, 8'h22);
    bus_write(16'h0000, 8'h33);
    bus_read(16'h1800, "R5 alias write discarded");
    bus_read(16'h19FF, "R5 edge unchanged");

    // R6: out-of-window reads
    bus_read(16'h17FF, "R6 read below window");
    bus_read(16'h1A00, "R6 read above window");
    bus_read(16'hFFFF, "R6 read top");

    // R8: strobe falls while ack still high
    @(negedge clk);
    addr = 16'h1900; wdat = 8'h77; wr_n = 1'b0;
    begin
      int cyc;
      wait_ack(cyc);
    end
    wait_release();
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_n = 1'b0;
    quiet(10, "R8 strobe ignored while ack high");
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    quiet(8, "R8 no cycle without new edge");
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    model[9'h100] = 8'h77; known[9'h100] = 1'b1;
    bus_read(16'h1900, "R8 next read after rearm");

    // R9: both strobes together
    @(negedge clk);
    addr = 16'h1880; wdat = 8'hEE; wr_n = 1'b0; rd_n = 1'b0;
    quiet(10, "R9 double strobe ignored");
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(16'h1880, "R9 storage unchanged");

    // random traffic
    for (int t = 0; t < 200; t++) begin
      logic [15:0] a;
      logic [15:0] o;
      logic [7:0]  d;
      if (($urandom % 4) != 0) a = 16'h1800 + 16'($urandom % 512);
      else                     a = 16'($urandom);
      d = 8'($urandom);
      o = a - 16'h1800;
      if (($urandom % 2) == 0) bus_write(a, d);
      else if (!in_win(a) || known[o[8:0]]) bus_read(a, "R2 random read");
      else bus_write(a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule